// File: doc/BRIEF.md
# Scanline Sprite Selection Engine

Once per scanline this engine walks a sprite attribute table and picks the sprites that the next line will draw. It starts at entry 0 and follows each entry's link field. For every visited entry it decides whether the sprite covers the requested line. If it does, the engine checks two separate per-line budgets: a count of sprites and a count of 8-pixel tiles. Each accepted sprite is sent out as a one-cycle record holding its table index and the number of tiles it contributes.

A mode input selects the wide screen (320 pixels) or the narrow screen (256 pixels), and the mode sets both budgets. The wide mode allows 20 sprites and 40 tiles per line. The narrow mode allows 16 sprites and 32 tiles. When a budget runs out, the sprites later in scan order are the ones dropped, and an overflow flag is raised. A sprite with horizontal position 0 acts as a mask: it closes the line, but only when an ordinary sprite has already been accepted on that line.

The attribute memory sits outside the block and is read without latency. The engine drives an address and sees that entry's fields in the same cycle, so each entry costs one clock.

Top module: `sprite_line_sel`

## Requirements
- R1: After reset, spr_valid, done and overflow are all 0.
- R2: A scan begins on a start pulse seen while idle. The first entry visited is entry 0, and each following entry is the one named by the current entry's link field. The scan ends after an entry whose link is 0, or after 64 entries have been visited, whichever comes first. Records appear in visit order. If a scan evaluates N entries and start is sampled at clock edge E0, done is high in the cycle after edge EN.
- R3: A sprite is on the line when 0 <= line - Y < 8*(H+1). H is rd_h, a 2-bit field where code 0 means 1 tile. Its width in tiles is rd_w + 1, with rd_w also a 2-bit field. The subtraction is unsigned, and a Y below the line wraps to "not on the line". Sprites that are not on the line produce no record.
- R4: Each on-line sprite is accepted in turn. When wide=1, at most 20 sprites are accepted; when wide=0, at most 16. An on-line sprite that arrives when the count is already at the limit is not listed: it sets overflow and ends the scan. Reaching the limit exactly does not set overflow.
- R5: Tiles are counted against a cap of 40 when wide=1 and 32 when wide=0. A sprite whose width fits the remaining room is listed with its full width. A sprite wider than the remaining room is listed with only the remaining tiles, sets overflow and ends the scan. An on-line sprite that arrives when the room is already 0 is not listed, sets overflow and ends the scan.
- R6: An on-line sprite with rd_x = 0 that arrives after at least one sprite with a nonzero rd_x has been accepted ends the scan. It is not listed and does not set overflow. An entry with rd_x = 0 that is not on the line has no effect.
- R7: An on-line sprite with rd_x = 0 that arrives before any sprite with a nonzero rd_x has been accepted is listed like any other sprite and uses up budget, but it does not arm the masking rule.
- R8: done is high for exactly one cycle per scan. overflow is cleared when a scan starts and then holds its value from done until the next accepted start.
- R9: A start pulse that arrives while a scan is running is ignored, and the scan's results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan (honoured only while idle) |
| line | input | 9 | Line number tested against each sprite's Y |
| wide | input | 1 | 1 = 320-pixel mode, 0 = 256-pixel mode |
| rd_addr | output | 6 | Attribute table entry being read |
| rd_y | input | 9 | Y of the addressed entry |
| rd_x | input | 9 | X of the addressed entry (0 = mask) |
| rd_w | input | 2 | Width code, tiles = code + 1 |
| rd_h | input | 2 | Height code, tiles = code + 1 |
| rd_link | input | 6 | Next entry to visit, 0 ends the chain |
| spr_valid | output | 1 | A selected-sprite record is present |
| spr_idx | output | 6 | Table index of the selected sprite |
| spr_tiles | output | 3 | Tiles the sprite contributes (1 to 4) |
| done | output | 1 | One-cycle pulse at the end of a scan |
| overflow | output | 1 | A budget was exceeded on this line |

## Verification
A wrong visit pointer or step counter shows up as records in the wrong order, or as done arriving one or more cycles away from the entry count. Both are visible in the first scan that follows a chain out of table order or runs to the 64-entry bound. A wrong sprite or tile counter shows up only once a line nears its budget. It then appears as a record count off by one, a wrong partial width on the last record, or an overflow flag that disagrees with the expected value at done. A stale masking flag appears only on a line that contains a position-0 sprite, where it either cuts the list short or fails to cut it.

// File: rtl/sls_pkg.sv
package sls_pkg;
    typedef enum logic {
        SLS_IDLE = 1'b0,
        SLS_SCAN = 1'b1
    } sls_state_e;

    // width of a sprite in tiles from its 2-bit code
    function automatic logic [2:0] code_tiles(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction
endpackage

// File: rtl/sls_hit.sv
module sls_hit #(
    parameter int LINE_W = 9,
    parameter int POS_W  = 9
) (
    input  logic [LINE_W-1:0] line,
    input  logic [POS_W-1:0]  y,
    input  logic [1:0]        hcode,
    output logic              hit
);
    localparam int DW = ((LINE_W > POS_W) ? LINE_W : POS_W) + 1;

    logic [DW-1:0] diff;
    logic [DW-2:0] height_px;

    always_comb begin
        diff      = DW'(line) - DW'(y);
        height_px = (DW-1)'({hcode, 3'b000}) + (DW-1)'(8);
        hit       = !diff[DW-1] && (diff[DW-2:0] < height_px);
    end
endmodule

// File: rtl/sls_budget.sv
module sls_budget #(
    parameter int CNT_W  = 5,
    parameter int TILE_W = 6
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [TILE_W-1:0] tiles,
    input  logic [CNT_W-1:0]  cnt_lim,
    input  logic [TILE_W-1:0] tile_cap,
    input  logic [1:0]        wcode,
    output logic              cnt_full,
    output logic              tile_full,
    output logic [2:0]        grant,
    output logic              partial
);
    logic [TILE_W-1:0] room;
    logic [TILE_W-1:0] need;

    always_comb begin
        room      = tile_cap - tiles;
        need      = TILE_W'(sls_pkg::code_tiles(wcode));
        cnt_full  = (cnt >= cnt_lim);
        tile_full = (tiles >= tile_cap);
        partial   = (need > room);
        grant     = partial ? room[2:0] : need[2:0];
    end
endmodule

// File: rtl/sprite_line_sel.sv
module sprite_line_sel #(
    parameter int NUM_ENTRIES  = 64,
    parameter int LINE_W       = 9,
    parameter int POS_W        = 9,
    parameter int WIDE_SPR     = 20,
    parameter int NARROW_SPR   = 16,
    parameter int WIDE_TILES   = 40,
    parameter int NARROW_TILES = 32,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] line,
    input  logic              wide,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [POS_W-1:0]  rd_y,
    input  logic [POS_W-1:0]  rd_x,
    input  logic [1:0]        rd_w,
    input  logic [1:0]        rd_h,
    input  logic [IDX_W-1:0]  rd_link,
    output logic              spr_valid,
    output logic [IDX_W-1:0]  spr_idx,
    output logic [2:0]        spr_tiles,
    output logic              done,
    output logic              overflow
);
    import sls_pkg::*;

    localparam int MAX_SPR   = (WIDE_SPR > NARROW_SPR) ? WIDE_SPR : NARROW_SPR;
    localparam int MAX_TILES = (WIDE_TILES > NARROW_TILES) ? WIDE_TILES : NARROW_TILES;
    localparam int CNT_W     = $clog2(MAX_SPR + 1);
    localparam int TILE_W    = $clog2(MAX_TILES + 1);

    typedef struct packed {
        sls_state_e        st;
        logic [IDX_W-1:0]  cur;
        logic [IDX_W-1:0]  vis;
        logic [CNT_W-1:0]  cnt;
        logic [TILE_W-1:0] tiles;
        logic              armed;
        logic              ovf;
        logic              done;
        logic              emit;
        logic [IDX_W-1:0]  eidx;
        logic [2:0]        etiles;
    } sls_regs_t;

    sls_regs_t r_q, r_d;

    logic              hit;
    logic              cnt_full, tile_full, partial;
    logic [2:0]        grant;
    logic [CNT_W-1:0]  cnt_lim;
    logic [TILE_W-1:0] tile_cap;
    logic              is_mask;
    logic              halt;

    assign cnt_lim  = wide ? CNT_W'(WIDE_SPR)    : CNT_W'(NARROW_SPR);
    assign tile_cap = wide ? TILE_W'(WIDE_TILES) : TILE_W'(NARROW_TILES);
    assign is_mask  = (rd_x == '0);

    sls_hit #(.LINE_W(LINE_W), .POS_W(POS_W)) u_hit (
        .line  (line),
        .y     (rd_y),
        .hcode (rd_h),
        .hit   (hit)
    );

    sls_budget #(.CNT_W(CNT_W), .TILE_W(TILE_W)) u_budget (
        .cnt       (r_q.cnt),
        .tiles     (r_q.tiles),
        .cnt_lim   (cnt_lim),
        .tile_cap  (tile_cap),
        .wcode     (rd_w),
        .cnt_full  (cnt_full),
        .tile_full (tile_full),
        .grant     (grant),
        .partial   (partial)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.emit = 1'b0;
        halt     = 1'b0;
        case (r_q.st)
            SLS_IDLE: begin
                if (start) begin
                    r_d.st    = SLS_SCAN;
                    r_d.cur   = '0;
                    r_d.vis   = '0;
                    r_d.cnt   = '0;
                    r_d.tiles = '0;
                    r_d.armed = 1'b0;
                    r_d.ovf   = 1'b0;
                end
            end
            SLS_SCAN: begin
                if (hit) begin
                    if (is_mask && r_q.armed) begin
                        halt = 1'b1;
                    end else if (cnt_full || tile_full) begin
                        halt    = 1'b1;
                        r_d.ovf = 1'b1;
                    end else begin
                        r_d.emit   = 1'b1;
                        r_d.eidx   = r_q.cur;
                        r_d.etiles = grant;
                        r_d.cnt    = r_q.cnt + CNT_W'(1);
                        r_d.tiles  = r_q.tiles + TILE_W'(grant);
                        if (!is_mask) r_d.armed = 1'b1;
                        if (partial) begin
                            halt    = 1'b1;
                            r_d.ovf = 1'b1;
                        end
                    end
                end
                if (halt || (rd_link == '0) || (r_q.vis == IDX_W'(NUM_ENTRIES - 1))) begin
                    r_d.st   = SLS_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cur = rd_link;
                    r_d.vis = r_q.vis + IDX_W'(1);
                end
            end
            default: r_d.st = SLS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_addr   = r_q.cur;
    assign spr_valid = r_q.emit;
    assign spr_idx   = r_q.eidx;
    assign spr_tiles = r_q.etiles;
    assign done      = r_q.done;
    assign overflow  = r_q.ovf;
endmodule

// File: rtl/sls_line_checker.sv
module sls_line_checker #(
    parameter int WIDE_SPR     = 20,
    parameter int NARROW_SPR   = 16,
    parameter int WIDE_TILES   = 40,
    parameter int NARROW_TILES = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       wide,
    input logic       spr_valid,
    input logic [2:0] spr_tiles,
    input logic       done,
    input logic       overflow
);
    logic quiet_q;
    logic mode_q;
    int   spr_acc_q;
    int   tile_acc_q;
    logic take;

    assign take = start && (quiet_q || done);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q    <= 1'b1;
            mode_q     <= 1'b1;
            spr_acc_q  <= 0;
            tile_acc_q <= 0;
        end else if (take) begin
            quiet_q    <= 1'b0;
            mode_q     <= wide;
            spr_acc_q  <= 0;
            tile_acc_q <= 0;
        end else begin
            if (done) quiet_q <= 1'b1;
            if (spr_valid) begin
                spr_acc_q  <= spr_acc_q + 1;
                tile_acc_q <= tile_acc_q + int'(spr_tiles);
            end
        end
    end

    // R3
    tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_valid |-> (spr_tiles >= 3'd1 && spr_tiles <= 3'd4));

    // R4
    spr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_valid |-> (spr_acc_q < (mode_q ? WIDE_SPR : NARROW_SPR)));

    // R5
    tile_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_valid |-> (tile_acc_q + int'(spr_tiles) <= (mode_q ? WIDE_TILES : NARROW_TILES)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q && !start) |=> $stable(overflow));

    // R2
    quiet_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q |-> !spr_valid);
endmodule

bind sprite_line_sel sls_line_checker #(
    .WIDE_SPR     (WIDE_SPR),
    .NARROW_SPR   (NARROW_SPR),
    .WIDE_TILES   (WIDE_TILES),
    .NARROW_TILES (NARROW_TILES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wide      (wide),
    .spr_valid (spr_valid),
    .spr_tiles (spr_tiles),
    .done      (done),
    .overflow  (overflow)
);

// File: tb/tb_sprite_line_sel.sv
`timescale 1ns/1ps
module tb_sprite_line_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] line = '0;
    logic       wide = 1'b1;
    logic [5:0] rd_addr;
    logic [8:0] rd_y, rd_x;
    logic [1:0] rd_w, rd_h;
    logic [5:0] rd_link;
    logic       spr_valid;
    logic [5:0] spr_idx;
    logic [2:0] spr_tiles;
    logic       done, overflow;

    logic [8:0] my [64];
    logic [8:0] mx [64];
    logic [1:0] mw [64];
    logic [1:0] mh [64];
    logic [5:0] ml [64];

    assign rd_y    = my[rd_addr];
    assign rd_x    = mx[rd_addr];
    assign rd_w    = mw[rd_addr];
    assign rd_h    = mh[rd_addr];
    assign rd_link = ml[rd_addr];

    always #2.5 clk = ~clk;

    sprite_line_sel dut (
        .clk(clk), .rst_n(rst_n), .start(start), .line(line), .wide(wide),
        .rd_addr(rd_addr), .rd_y(rd_y), .rd_x(rd_x), .rd_w(rd_w), .rd_h(rd_h),
        .rd_link(rd_link), .spr_valid(spr_valid), .spr_idx(spr_idx),
        .spr_tiles(spr_tiles), .done(done), .overflow(overflow)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    int got_idx [64];
    int got_t   [64];
    int n_got;
    int exp_idx [64];
    int exp_t   [64];
    int n_exp;
    int cyc;
    logic done_after;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_tab();
        for (int i = 0; i < 64; i++) begin
            my[i] = 9'd500; mx[i] = 9'd10; mw[i] = 2'd0; mh[i] = 2'd0;
            ml[i] = (i == 63) ? 6'd0 : 6'(i + 1);
        end
        n_exp = 0;
    endtask

    task automatic put(input int i, input int y, input int h, input int w, input int x);
        my[i] = 9'(y); mh[i] = 2'(h); mw[i] = 2'(w); mx[i] = 9'(x);
    endtask

    task automatic add_exp(input int i, input int t);
        exp_idx[n_exp] = i; exp_t[n_exp] = t; n_exp++;
    endtask

    task automatic run_line(input int ln, input logic wd, input int again);
        bit fin;
        n_got = 0; fin = 0;
        line = 9'(ln); wide = wd;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!fin && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (spr_valid) begin
                got_idx[n_got] = int'(spr_idx);
                got_t[n_got]   = int'(spr_tiles);
                n_got++;
            end
            if (done) fin = 1;
            start = (!fin && cyc == again);
        end
        start = 1'b0;
        @(negedge clk) done_after = done;
    endtask

    task automatic check_line(input string tag, input int exp_cyc, input int exp_ovf);
        chk({tag, " record count"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk({tag, " index"}, got_idx[i], exp_idx[i]);
            chk({tag, " tiles"}, got_t[i], exp_t[i]);
        end
        chk({tag, " done cycle"}, cyc, exp_cyc);
        chk({tag, " overflow"}, int'(overflow), exp_ovf);
        chk({tag, " R8 done one cycle"}, int'(done_after), 0);
    endtask

    // R3 on-line window and widths
    task automatic t_basic();
        clear_tab();
        ml[5] = 6'd0;
        put(0, 100, 0, 1, 50); add_exp(0, 2);
        put(1, 90, 0, 0, 50);
        put(2, 93, 0, 3, 50);  add_exp(2, 4);
        put(3, 101, 0, 0, 50);
        put(4, 70, 3, 0, 50);  add_exp(4, 1);
        put(5, 68, 3, 0, 50);
        run_line(100, 1'b1, -1);
        check_line("R3 basic", 6, 0);
    endtask

    // R2 link order
    task automatic t_links();
        clear_tab();
        for (int i = 0; i < 6; i++) put(i, 100, 0, 0, 20);
        ml[0] = 6'd5; ml[5] = 6'd3; ml[3] = 6'd0;
        add_exp(0, 1); add_exp(5, 1); add_exp(3, 1);
        run_line(100, 1'b1, -1);
        check_line("R2 link order", 3, 0);
    endtask

    // R2 table-size bound with looping chain
    task automatic t_bound();
        clear_tab();
        ml[63] = 6'd1;
        put(63, 100, 0, 2, 20); add_exp(63, 3);
        run_line(100, 1'b1, -1);
        check_line("R2 table bound", 64, 0);
    endtask

    // R4 sprite count limits
    task automatic t_count();
        clear_tab();
        ml[21] = 6'd0;
        for (int i = 0; i < 22; i++) put(i, 100, 0, 0, 20);
        for (int i = 0; i < 20; i++) add_exp(i, 1);
        run_line(100, 1'b1, -1);
        check_line("R4 wide over", 21, 1);

        clear_tab();
        ml[19] = 6'd0;
        for (int i = 0; i < 20; i++) begin put(i, 100, 0, 0, 20); add_exp(i, 1); end
        run_line(100, 1'b1, -1);
        check_line("R4 wide exact", 20, 0);

        clear_tab();
        ml[19] = 6'd0;
        for (int i = 0; i < 17; i++) put(i, 100, 0, 0, 20);
        for (int i = 0; i < 16; i++) add_exp(i, 1);
        run_line(100, 1'b0, -1);
        check_line("R4 narrow over", 17, 1);
    endtask

    // R5 tile caps
    task automatic t_tiles();
        clear_tab();
        ml[11] = 6'd0;
        for (int i = 0; i < 12; i++) put(i, 100, 0, 3, 20);
        for (int i = 0; i < 10; i++) add_exp(i, 4);
        run_line(100, 1'b1, -1);
        check_line("R5 wide full", 11, 1);

        clear_tab();
        ml[11] = 6'd0;
        for (int i = 0; i < 12; i++) put(i, 100, 0, 3, 20);
        put(9, 100, 0, 2, 20);
        for (int i = 0; i < 9; i++) add_exp(i, 4);
        add_exp(9, 3); add_exp(10, 1);
        run_line(100, 1'b1, -1);
        check_line("R5 wide partial", 11, 1);

        clear_tab();
        ml[9] = 6'd0;
        for (int i = 0; i < 10; i++) put(i, 100, 0, 3, 20);
        put(7, 100, 0, 2, 20);
        for (int i = 0; i < 7; i++) add_exp(i, 4);
        add_exp(7, 3); add_exp(8, 1);
        run_line(100, 1'b0, -1);
        check_line("R5 narrow partial", 9, 1);
    endtask

    // R6 masking
    task automatic t_mask();
        clear_tab();
        ml[3] = 6'd0;
        put(0, 100, 0, 1, 10); put(1, 100, 0, 1, 0);
        put(2, 100, 0, 1, 10); put(3, 100, 0, 1, 10);
        add_exp(0, 2);
        run_line(100, 1'b1, -1);
        check_line("R6 mask stops", 2, 0);

        clear_tab();
        ml[3] = 6'd0;
        put(0, 100, 0, 1, 10); put(1, 500, 0, 1, 0);
        put(2, 100, 0, 1, 10); put(3, 100, 0, 1, 10);
        add_exp(0, 2); add_exp(2, 2); add_exp(3, 2);
        run_line(100, 1'b1, -1);
        check_line("R6 mask off line", 4, 0);
    endtask

    // R7 position-0 sprites before any ordinary one
    task automatic t_zero_first();
        clear_tab();
        ml[4] = 6'd0;
        put(0, 100, 0, 0, 0); put(1, 100, 0, 0, 0); put(2, 100, 0, 0, 5);
        put(3, 100, 0, 0, 0); put(4, 100, 0, 0, 5);
        add_exp(0, 1); add_exp(1, 1); add_exp(2, 1);
        run_line(100, 1'b1, -1);
        check_line("R7 zero first", 4, 0);
    endtask

    // R8 overflow holding and clearing
    task automatic t_hold();
        clear_tab();
        ml[21] = 6'd0;
        for (int i = 0; i < 22; i++) put(i, 100, 0, 0, 20);
        for (int i = 0; i < 20; i++) add_exp(i, 1);
        run_line(100, 1'b1, -1);
        repeat (5) @(negedge clk);
        chk("R8 overflow held", int'(overflow), 1);
        chk("R8 done low idle", int'(done), 0);
        clear_tab();
        ml[0] = 6'd0;
        put(0, 100, 0, 0, 20); add_exp(0, 1);
        run_line(100, 1'b1, -1);
        check_line("R8 overflow cleared", 1, 0);
    endtask

    // R9 start ignored mid-scan
    task automatic t_restart();
        clear_tab();
        ml[7] = 6'd0;
        put(1, 100, 0, 1, 20); put(4, 100, 0, 2, 20); put(6, 100, 0, 0, 20);
        add_exp(1, 2); add_exp(4, 3); add_exp(6, 1);
        run_line(100, 1'b1, 2);
        check_line("R9 start ignored", 8, 0);
    endtask

    initial begin
        clear_tab();
        repeat (3) @(negedge clk);
        // R1
        chk("R1 spr_valid reset", int'(spr_valid), 0);
        chk("R1 done reset", int'(done), 0);
        chk("R1 overflow reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_links();
        t_bound();
        t_count();
        t_tiles();
        t_mask();
        t_zero_first();
        t_hold();
        t_restart();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule